// File: doc/BRIEF.md
# Clamped-Duty PWM Generator

This block is a free-running pulse width modulator. A counter of `CNT_W` bits advances once per system clock, so one output period lasts 2^CNT_W clocks. With the default width of 12 and a 100 MHz clock, that is about 24.4 kHz. The output is high for the first D clocks of each period, where D is the effective duty.

The duty command is read only when the counter is at zero. A command that changes partway through a period therefore cannot bend the waveform of that period. Before it is used, the sampled command is limited to a window set by two percentage parameters.

While `enable` is low, the counter rests at zero and the output stays low. Raising `enable` starts a fresh period immediately. Typical use is to drive a power stage or an indicator from a register that software rewrites at arbitrary times.

Top module: `duty_pwm`

## Requirements
- R1: While `enable` is high, `count` rises by one on every clock and wraps from 2^CNT_W−1 to 0, so a period is 2^CNT_W clocks.
- R2: Call the effective duty D, and say the clock edge that latches D sees `count` = 0. Over the next 2^CNT_W clocks, `pwm_out` is high exactly while `count` reads 1 through D and is low for the rest of those clocks. The output is a register, so it is high for the clocks after the counter values 0 .. D−1. The number of high clocks per period therefore equals D.
- R3: `duty_cmd` is sampled only on the clock edge at which `count` is 0. Changes at any other time do not affect the current period.
- R4: A sampled command below LO = floor(MIN_PCT·2^CNT_W/100) is raised to LO. With CNT_W=6 and MIN_PCT=10, LO is 6, so commands 0 and 5 give 6 high clocks.
- R5: A sampled command above HI = floor(MAX_PCT·2^CNT_W/100) is lowered to HI; with MAX_PCT=100 no upper limit applies. With CNT_W=6 and MAX_PCT=90, HI is 57, so commands 58 and 63 give 57 high clocks.
- R6: A command between LO and HI inclusive is used unchanged, including exactly LO and exactly HI.
- R7: One clock after `enable` is seen low, `count` is 0 and `pwm_out` is low. Both stay so while `enable` stays low, whatever `duty_cmd` does.
- R8: The first edge that sees `enable` high latches the duty and begins a period, so `count` reads 1 one clock after `enable` rises.
- R9: While the synchronous reset `rst` is high, `count` is 0 and `pwm_out` is low on the next clock and after, whatever `enable` and `duty_cmd` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run control; low holds the counter at zero and the output low |
| duty_cmd | input | CNT_W | Requested high time in clocks per period |
| pwm_out | output | 1 | Registered modulated output |
| count | output | CNT_W | Live period counter |

## Verification
The hardest situation to bring about is a duty command that changes in the middle of a period, because its effect must be zero. A wrong design would only show the error as a slightly different high time.

The stimulus sets the command while the counter reads zero and then rewrites it about twenty clocks into the period. The rewrite goes once to a larger value and once to a smaller one. A scoreboard counts the high clocks over each whole period and compares them with the command that was present at the period boundary, after clamping.

Commands below, at and above both limits exercise the clamp. Disabling partway through a period and re-enabling shows that the period restarts from zero.

// File: rtl/duty_pwm_pkg.sv
package duty_pwm_pkg;

   // Level in counter steps that corresponds to a percentage of full scale.
   function automatic int unsigned pct_level(int unsigned width, int unsigned pct);
      return (pct * (32'd1 << width)) / 100;
   endfunction

endpackage

// File: rtl/duty_pwm_counter.sv
module duty_pwm_counter #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   output logic [CNT_W-1:0] count,
   output logic             at_zero
);

   localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (rst || !en) count <= '0;
      else            count <= count + 1'b1;
   end

   assign at_zero = (count == '0);

   // R1: terminal value is followed by zero
   a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
      (en && count == TOP_VAL) |=> (count == '0));

   // R1: single step otherwise
   a_r1_step: assert property (@(posedge clk) disable iff (rst)
      (en && count != TOP_VAL) |=> (count == CNT_W'($past(count) + 1'b1)));

endmodule

// File: rtl/duty_pwm_clamp.sv
module duty_pwm_clamp #(
   parameter int unsigned      CNT_W  = 12,
   parameter logic [CNT_W-1:0] LO_V   = '0,
   parameter logic [CNT_W-1:0] HI_V   = '1,
   parameter bit               USE_LO = 1'b0,
   parameter bit               USE_HI = 1'b1
) (
   input  logic [CNT_W-1:0] raw,
   output logic [CNT_W-1:0] limited
);

   logic [CNT_W-1:0] floor_stage;

   generate
      if (USE_LO) begin : g_lo
         assign floor_stage = (raw < LO_V) ? LO_V : raw;
      end else begin : g_no_lo
         assign floor_stage = raw;
      end

      if (USE_HI) begin : g_hi
         assign limited = (floor_stage > HI_V) ? HI_V : floor_stage;
      end else begin : g_no_hi
         assign limited = floor_stage;
      end
   endgenerate

endmodule

// File: rtl/duty_pwm_latch.sv
module duty_pwm_latch #(
   parameter int unsigned      CNT_W  = 12,
   parameter logic [CNT_W-1:0] LO_V   = '0,
   parameter logic [CNT_W-1:0] HI_V   = '1,
   parameter bit               USE_LO = 1'b0,
   parameter bit               USE_HI = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             at_zero,
   input  logic [CNT_W-1:0] limited,
   output logic [CNT_W-1:0] duty_eff
);

   logic [CNT_W-1:0] duty_q;

   always_ff @(posedge clk) begin
      if (rst)                 duty_q <= '0;
      else if (en && at_zero)  duty_q <= limited;
   end

   // At the boundary the fresh command is compared directly; later the held copy.
   assign duty_eff = at_zero ? limited : duty_q;

   // R3: held value cannot move away from the period boundary
   a_r3_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
      !at_zero |=> $stable(duty_q));

   generate
      if (USE_LO) begin : g_chk_lo
         // R4: latched duty never under the floor
         a_r4_above_floor: assert property (@(posedge clk) disable iff (rst)
            (en && at_zero) |=> (duty_q >= LO_V));
      end
      if (USE_HI) begin : g_chk_hi
         // R5: latched duty never over the ceiling
         a_r5_below_ceiling: assert property (@(posedge clk) disable iff (rst)
            (en && at_zero) |=> (duty_q <= HI_V));
      end
   endgenerate

endmodule

// File: rtl/duty_pwm.sv
module duty_pwm #(
   parameter int unsigned CNT_W   = 12,
   parameter int unsigned MIN_PCT = 0,
   parameter int unsigned MAX_PCT = 95
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enable,
   input  logic [CNT_W-1:0] duty_cmd,
   output logic             pwm_out,
   output logic [CNT_W-1:0] count
);

   import duty_pwm_pkg::*;

   localparam int unsigned FULL_SCALE = 32'd1 << CNT_W;
   localparam int unsigned LO_INT     = pct_level(CNT_W, MIN_PCT);
   localparam int unsigned HI_INT     = pct_level(CNT_W, MAX_PCT);
   localparam int unsigned HI_CAP     = (HI_INT > FULL_SCALE - 1) ? FULL_SCALE - 1 : HI_INT;
   localparam bit          USE_LO     = (MIN_PCT > 0);
   localparam bit          USE_HI     = (MAX_PCT < 100);
   localparam logic [CNT_W-1:0] LO_V  = CNT_W'(LO_INT);
   localparam logic [CNT_W-1:0] HI_V  = CNT_W'(HI_CAP);

   generate
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
         $error("duty_pwm: CNT_W must lie in 2..24");
      end
      if (MAX_PCT > 100) begin : g_bad_max
         $error("duty_pwm: MAX_PCT above 100");
      end
      if (MIN_PCT > MAX_PCT) begin : g_bad_order
         $error("duty_pwm: MIN_PCT exceeds MAX_PCT");
      end
   endgenerate

   logic             at_zero;
   logic [CNT_W-1:0] limited;
   logic [CNT_W-1:0] duty_eff;

   duty_pwm_counter #(.CNT_W(CNT_W)) u_counter (
      .clk     (clk),
      .rst     (rst),
      .en      (enable),
      .count   (count),
      .at_zero (at_zero)
   );

   duty_pwm_clamp #(
      .CNT_W(CNT_W), .LO_V(LO_V), .HI_V(HI_V), .USE_LO(USE_LO), .USE_HI(USE_HI)
   ) u_clamp (
      .raw     (duty_cmd),
      .limited (limited)
   );

   duty_pwm_latch #(
      .CNT_W(CNT_W), .LO_V(LO_V), .HI_V(HI_V), .USE_LO(USE_LO), .USE_HI(USE_HI)
   ) u_latch (
      .clk      (clk),
      .rst      (rst),
      .en       (enable),
      .at_zero  (at_zero),
      .limited  (limited),
      .duty_eff (duty_eff)
   );

   always_ff @(posedge clk) begin
      if (rst) pwm_out <= 1'b0;
      else     pwm_out <= enable && (count < duty_eff);
   end

   // R7: idle state one clock after enable is low
   a_r7_idle_when_off: assert property (@(posedge clk) disable iff (rst)
      !enable |=> (!pwm_out && count == '0));

   // R9: reset clears output and counter
   a_r9_reset_clears: assert property (@(posedge clk)
      rst |=> (!pwm_out && count == '0));

endmodule

// File: tb/tb_duty_pwm.sv
module tb_duty_pwm;

   localparam int W    = 6;
   localparam int PER  = 64;
   localparam int MINP = 10;
   localparam int MAXP = 90;
   localparam int LO   = (MINP * PER) / 100;
   localparam int HI   = (MAXP * PER) / 100;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         enable = 1'b0;
   logic [W-1:0] duty_cmd = '0;
   logic         pwm_out;
   logic [W-1:0] count;

   int    vectors = 0;
   int    miscompares = 0;
   bit    done = 1'b0;
   int    exp_q[$];
   string req_q[$];

   always #10 clk = ~clk;

   duty_pwm #(.CNT_W(W), .MIN_PCT(MINP), .MAX_PCT(MAXP)) dut (
      .clk(clk), .rst(rst), .enable(enable), .duty_cmd(duty_cmd),
      .pwm_out(pwm_out), .count(count)
   );

   function automatic int clampv(int c);
      if (c < LO) return LO;
      if (c > HI) return HI;
      return c;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   // Monitor: counts high clocks across each period window (count reads 1..PER-1, then 0)
   bit    win_open = 1'b0;
   int    win_n = 0;
   int    win_h = 0;
   int    e_val;
   string r_tag;
   always @(posedge clk) begin
      #5;
      if (rst || !enable) begin
         win_open = 1'b0;
      end else begin
         if (!win_open && count == 1) begin
            win_open = 1'b1;
            win_n = 0;
            win_h = 0;
         end
         if (win_open) begin
            win_h += int'(pwm_out);
            win_n++;
            if (win_n == PER) begin
               win_open = 1'b0;
               if (exp_q.size() > 0) begin
                  e_val = exp_q.pop_front();
                  r_tag = req_q.pop_front();
                  check(win_h == e_val, r_tag, win_h, e_val);
               end
            end
         end
      end
   end

   // Driver: start from idle with a command
   task automatic start_run(int cmd, string req);
      @(negedge clk);
      duty_cmd = W'(cmd);
      enable = 1'b1;
      exp_q.push_back(clampv(cmd));
      req_q.push_back(req);
   endtask

   // Driver: set command at the boundary, then rewrite it mid-period
   task automatic drive_period(int cmd, int mid, string req);
      do @(negedge clk); while (count != 0);
      duty_cmd = W'(cmd);
      exp_q.push_back(clampv(cmd));
      req_q.push_back(req);
      repeat (20) @(negedge clk);
      duty_cmd = W'(mid);
   endtask

   initial begin
      // R9: reset dominates enable
      enable = 1'b1;
      duty_cmd = 6'd40;
      repeat (4) @(negedge clk);
      check(count == 0, "R9 count in reset", int'(count), 0);
      check(pwm_out == 1'b0, "R9 pwm in reset", int'(pwm_out), 0);
      rst = 1'b0;
      enable = 1'b0;
      repeat (3) @(negedge clk);
      check(count == 0, "R7 count idle", int'(count), 0);
      check(pwm_out == 1'b0, "R7 pwm idle", int'(pwm_out), 0);

      // R8: first period right after enable
      start_run(20, "R8 first period duty");
      @(negedge clk);
      check(count == 1, "R8 count after rise", int'(count), 1);

      drive_period(63, 63, "R5 full-scale clamp");
      drive_period(0, 0, "R4 zero raised");
      drive_period(LO, LO, "R6 exactly LO");
      drive_period(HI, HI, "R6 exactly HI");
      drive_period(30, 60, "R3 mid raise ignored");
      drive_period(10, 0, "R3 mid drop ignored");
      drive_period(45, 45, "R2 plain duty");
      drive_period(58, 58, "R5 one over HI");
      drive_period(5, 5, "R4 one under LO");

      // R1: wrap and step
      do @(negedge clk); while (count != PER - 1);
      @(negedge clk);
      check(count == 0, "R1 wrap to zero", int'(count), 0);
      @(negedge clk);
      check(count == 1, "R1 step after wrap", int'(count), 1);

      // R7: disable mid-period, command changes ignored while off
      do @(negedge clk); while (count != 10);
      enable = 1'b0;
      @(negedge clk);
      check(count == 0, "R7 count after drop", int'(count), 0);
      check(pwm_out == 1'b0, "R7 pwm after drop", int'(pwm_out), 0);
      duty_cmd = 6'd50;
      repeat (5) @(negedge clk);
      check(count == 0, "R7 count held", int'(count), 0);
      check(pwm_out == 1'b0, "R7 pwm held", int'(pwm_out), 0);

      // R8: restart from a fresh period
      start_run(63, "R8 restart clamp");
      @(negedge clk);
      check(count == 1, "R8 restart count", int'(count), 1);
      repeat (PER + 5) @(negedge clk);

      check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL R1 watchdog: actual 0 expected 1 completion");
      finish_run();
   end

endmodule